// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory with Mode Decoding

This block models a one-time-programmable byte memory as a clocked digital macro. Two active-low strobes control it: a chip select and an output enable. Two digital flags stand in for the high-voltage levels of the physical part. One flag sits on the output-enable/program line and selects programming. The other sits on address bit 9 and selects product identification. The tristate data pins are split into three signals: a data-out, a data-in and a drive-enable. A pad ring or bus fabric can rebuild the shared pin from these.

After reset every cell holds all ones. A program strobe can only turn ones into zeros, because it merges the applied byte into the stored byte with a bitwise AND. While the identification flag is raised, the array is not read. The outputs instead carry fixed identification bytes, selected by the two lowest address bits. Each of these bytes has odd parity, with bit 7 as the parity bit.

Top module: `otp_byte_mem`

## Requirements
- R1: After reset every cell of the array reads 0xFF.
- R2: With `ce_n` high, `dout_en` is 0 whatever the values of `oe_n`, `vpp_hi` and `id_hi`.
- R3: `dout_en` is 1 only when `ce_n`=0, `oe_n`=0 and `vpp_hi`=0. In that case, with `id_hi`=0, `dout` equals the byte stored at `addr`.
- R4: At each rising clock edge with `vpp_hi`=1 and `ce_n`=0, the cell at `addr` becomes its old value AND `din`.
- R5: Programming never changes a stored 0 back to 1.
- R6: At a rising edge with `vpp_hi`=1 and `ce_n`=1, no cell changes.
- R7: With `id_hi`=1 and `addr[1]`=1, `dout` is 0x1C when `addr[0]`=0 and 0x83 when `addr[0]`=1.
- R8: With `id_hi`=1 and `addr[1]`=0, `dout` is 0x7F for either value of `addr[0]`.
- R9: Every identification byte has an odd number of ones, with bit 7 acting as the parity bit.
- R10: While `id_hi`=1, `dout` shows the identification byte and never the array contents.
- R11: While `vpp_hi`=1, `dout_en` is 0.
- R12: With `ce_n`=0 and `oe_n`=1, `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; program strobes take effect on its rising edge |
| rst_n | input | 1 | Active-low reset; returns the array to its blank state |
| ce_n | input | 1 | Active-low chip select / program strobe |
| oe_n | input | 1 | Active-low output enable |
| vpp_hi | input | 1 | Program-voltage flag on the output-enable/program line |
| id_hi | input | 1 | High-voltage flag on address bit 9; selects identification |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte to program |
| dout | output | 8 | Read or identification byte |
| dout_en | output | 1 | Data-pin drive enable |

## Verification
The clocked properties assume that `addr` and the control lines are free of X from the first clock after reset. They also assume that only the rising edge of `clk` takes a program strobe. The stimulus changes inputs just after the falling edge and holds them through the next rising edge. It keeps every input at a known level from time zero, so each program or inhibit cycle presents one stable address to the properties. Reset is held for several cycles before any strobe, so the array starts in its blank state.

// File: rtl/otp_byte_mem.sv
module otp_byte_mem #(
  parameter int ADDR_W = 10,
  parameter logic [6:0] MFR_LO  = 7'h1C,
  parameter logic [6:0] DEV_LO  = 7'h03,
  parameter logic [6:0] CONT_LO = 7'h7F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              id_hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];
  logic [6:0] id_lo;
  logic [7:0] id_byte;
  logic       prog_strobe;

  assign prog_strobe = vpp_hi && !ce_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (prog_strobe) begin
      cells[addr] <= cells[addr] & din;
    end
  end

  assign id_lo   = addr[1] ? (addr[0] ? DEV_LO : MFR_LO) : CONT_LO;
  assign id_byte = {~^id_lo, id_lo};

  assign dout    = id_hi ? id_byte : cells[addr];
  assign dout_en = !ce_n && !oe_n && !vpp_hi;

  // R2
  standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_en);

  // R12
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);

  // R11
  prog_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_hi |-> !dout_en);

  // R6
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_hi && ce_n) |=> cells[$past(addr)] == $past(cells[addr]));

  // R5
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cells[$past(addr)] & ~$past(cells[addr])) == 8'h00);

  // R9
  id_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_hi |-> (^dout) == 1'b1);
endmodule

// File: tb/tb_otp_byte_mem.sv
module tb_otp_byte_mem;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, id_hi = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = 8'hFF;
  logic [7:0]    dout;
  logic          dout_en;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  otp_byte_mem #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .id_hi(id_hi), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  always #5 clk = ~clk;

  // {ce_n, oe_n, vpp_hi, id_hi}, addr, din, expected enable, expected byte
  localparam int NV = 20;
  localparam logic [30:0] VEC [NV] = '{
    {4'b0000, 10'd5,    8'h00, 1'b1, 8'hFF},
    {4'b0010, 10'd5,    8'hA5, 1'b0, 8'h00},
    {4'b0000, 10'd5,    8'h00, 1'b1, 8'hA5},
    {4'b0010, 10'd5,    8'h5A, 1'b0, 8'h00},
    {4'b0000, 10'd5,    8'h00, 1'b1, 8'h00},
    {4'b0010, 10'd5,    8'hFF, 1'b0, 8'h00},
    {4'b0000, 10'd5,    8'h00, 1'b1, 8'h00},
    {4'b1010, 10'd7,    8'h00, 1'b0, 8'h00},
    {4'b0000, 10'd7,    8'h00, 1'b1, 8'hFF},
    {4'b1000, 10'd5,    8'h00, 1'b0, 8'h00},
    {4'b1100, 10'd5,    8'h00, 1'b0, 8'h00},
    {4'b0100, 10'd5,    8'h00, 1'b0, 8'h00},
    {4'b0001, 10'd2,    8'h00, 1'b1, 8'h1C},
    {4'b0001, 10'd3,    8'h00, 1'b1, 8'h83},
    {4'b0001, 10'd0,    8'h00, 1'b1, 8'h7F},
    {4'b0001, 10'd1,    8'h00, 1'b1, 8'h7F},
    {4'b0001, 10'd5,    8'h00, 1'b1, 8'h7F},
    {4'b1001, 10'd2,    8'h00, 1'b0, 8'h00},
    {4'b0010, 10'd1023, 8'h0F, 1'b0, 8'h00},
    {4'b0000, 10'd1023, 8'h00, 1'b1, 8'h0F}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] ctl, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    {ce_n, oe_n, vpp_hi, id_hi} = ctl;
    addr = a;
    din = d;
    #1;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    rst_n = 1'b1;

    // R1 blank state, R3 read path
    apply(4'b0000, 10'd0, 8'h00);
    check("R1 blank en", {7'd0, dout_en}, 8'h01);
    check("R1 blank byte", dout, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][30:27], VEC[i][26:17], VEC[i][16:9]);
      // R2 R3 R11 R12 drive enable
      check($sformatf("R3 vec%0d en", i), {7'd0, dout_en}, {7'd0, VEC[i][8]});
      // R4 R5 R6 R7 R8 R10 byte value
      if (VEC[i][8]) check($sformatf("R4 vec%0d byte", i), dout, VEC[i][7:0]);
      // R9 odd parity on identification bytes
      if (VEC[i][27]) check($sformatf("R9 vec%0d parity", i), {7'd0, ^dout}, 8'h01);
    end

    // R1 reset restores blank array after programming
    apply(4'b0010, 10'd9, 8'h00);
    apply(4'b0000, 10'd9, 8'h00);
    check("R4 pre-reset", dout, 8'h00);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    apply(4'b0000, 10'd9, 8'h00);
    check("R1 after reset", dout, 8'hFF);

    // R10 identification overrides a programmed cell at the same address
    apply(4'b0010, 10'd3, 8'h11);
    apply(4'b0001, 10'd3, 8'h00);
    check("R10 id over array", dout, 8'h83);
    apply(4'b0000, 10'd3, 8'h00);
    check("R3 array after id", dout, 8'h11);

    // R6 inhibit holds across several cycles
    apply(4'b1010, 10'd3, 8'h00);
    apply(4'b1010, 10'd3, 8'h00);
    apply(4'b0000, 10'd3, 8'h00);
    check("R6 inhibit held", dout, 8'h11);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule